// File: doc/BRIEF.md
# Timed Fetch-Decode-Execute Control Sequencer

This block is a compact 16-bit accumulator machine whose every register transfer is gated by a timing state and by the decoded operation. A sequence counter steps through states T0 to T6. The first three states fetch an instruction and decode it. State T3 resolves an indirect address with one extra memory read. The remaining states carry out one of the memory-reference operations. The counter then returns to T0 for the next instruction.

An instruction word holds a 12-bit address in bits 11:0, a 3-bit opcode in bits 14:12 and the indirect flag in bit 15. The opcodes are 0 AND, 1 ADD, 2 LDA (load accumulator), 3 STA (store accumulator), 4 BUN (branch), 5 BSA (branch and save return address) and 6 ISZ (increment and skip if zero). Opcode 7 halts the sequencer. The internal memory has 4096 words of 16 bits. A test environment fills it through a load port while reset is held and reads it back through a combinational peek port. After reset the program counter starts at the value of the START_PC parameter.

Top module: `acc_seq_top`

## Requirements
- R1: In state T0 the address register takes the value of the program counter.
- R2: In state T1 the instruction register takes the memory word at the address register, and the program counter increments by one.
- R3: In state T2 the address register takes instruction bits 11:0, and the indirect flag takes instruction bit 15. The opcode is instruction bits 14:12.
- R4: In state T3, when the indirect flag is 1 and the opcode is not 7, the address register takes bits 11:0 of the memory word it points at. Otherwise T3 changes no register. Every instruction except BUN, STA and halt passes through T3 to T5. An ADD instruction takes six cycles, direct or indirect.
- R5: ADD (opcode 1) reads the operand into the data register at T4. At T5 it sets {E, AC} to AC plus the data register, where E is the 17th bit, and returns to T0.
- R6: BUN (opcode 4) loads the program counter from the address register at T4 and returns to T0.
- R7: AND (opcode 0) sets AC to AC AND the operand at T5. LDA (opcode 2) sets AC to the operand at T5. Neither changes E.
- R8: STA (opcode 3) writes AC to memory at the effective address at T4 and returns to T0.
- R9: BSA (opcode 5) writes the incremented program counter to the effective address at T4 and also increments the address register. At T5 it loads the program counter from the address register.
- R10: ISZ (opcode 6) reads the operand at T4 and increments it at T5. At T6 it writes the operand back, increments the program counter if the new value is zero, and returns to T0. It takes seven cycles.
- R11: Opcode 7 sets `halted` at the end of T3. From then on the state stays at T3 and PC, AC and E hold until reset.
- R12: When `ldEn` is 1, `ldData` is written to memory at `ldAddr` on the clock edge. `peekData` always shows the memory word at `peekAddr`.
- R13: While reset is low, PC equals START_PC, AC, IR, DR and E are zero, the state is T0 and `halted` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ldEn | input | 1 | Memory load strobe |
| ldAddr | input | 12 | Memory load address |
| ldData | input | 16 | Memory load data |
| peekAddr | input | 12 | Memory read-back address |
| peekData | output | 16 | Memory word at peekAddr |
| pc | output | 12 | Program counter |
| ar | output | 12 | Address register |
| ir | output | 16 | Instruction register |
| dr | output | 16 | Data register |
| ac | output | 16 | Accumulator |
| eFlag | output | 1 | Carry flag E |
| indFlag | output | 1 | Indirect flag of the current instruction |
| tState | output | 3 | Current timing state (0 to 6) |
| halted | output | 1 | Sequencer stopped by opcode 7 |

## Verification
On every cycle, the assertions check the fetch and decode transfers of T0 to T2, that a direct instruction leaves AR unchanged at T3, the BUN and ADD results with their return to T0, the valid range of the state, and that the halted state is frozen. Only whole programs run by the bench can show the effects that reach memory and the cycle counts. These cover STA and BSA stores, the write-back and skip of ISZ, and indirect operand resolution. They also show that E survives AND and LDA, and the end state of the multi-instruction branch-and-add sequence.

// File: rtl/acc_seq_pkg.sv
package acc_seq_pkg;
  localparam int SC_W = 3;
  localparam int NUM_T = 7;
  localparam int NUM_OP = 8;

  localparam logic [2:0] OP_AND = 3'd0;
  localparam logic [2:0] OP_ADD = 3'd1;
  localparam logic [2:0] OP_LDA = 3'd2;
  localparam logic [2:0] OP_STA = 3'd3;
  localparam logic [2:0] OP_BUN = 3'd4;
  localparam logic [2:0] OP_BSA = 3'd5;
  localparam logic [2:0] OP_ISZ = 3'd6;
  localparam logic [2:0] OP_HLT = 3'd7;

  typedef struct packed {
    logic arFromPc;
    logic arFromIr;
    logic arFromMem;
    logic arInc;
    logic irLoad;
    logic pcInc;
    logic pcFromAr;
    logic drLoad;
    logic drInc;
    logic acAnd;
    logic acAdd;
    logic acFromDr;
    logic wrAc;
    logic wrPc;
    logic wrDr;
  } seq_strobe_t;
endpackage

// File: rtl/acc_seq_ctrl.sv
module acc_seq_ctrl
  import acc_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [3:0]        irHi,
  input  logic              drZero,
  output seq_strobe_t       strb,
  output logic [SC_W-1:0]   tState,
  output logic              indFlag,
  output logic              halted
);
  logic [SC_W-1:0] sc;
  logic [NUM_OP-1:0] dec;
  logic [NUM_T-1:0] tt;
  logic scClr;
  logic haltNow;

  for (genvar g = 0; g < NUM_OP; g++) begin : g_dec
    assign dec[g] = (irHi[2:0] == 3'(g));
  end

  for (genvar k = 0; k < NUM_T; k++) begin : g_tim
    assign tt[k] = (sc == SC_W'(k));
  end

  assign haltNow = tt[3] & dec[OP_HLT];

  always_comb begin
    strb = '0;
    strb.arFromPc  = tt[0];
    strb.irLoad    = tt[1];
    strb.pcInc     = tt[1] | (tt[6] & dec[OP_ISZ] & drZero);
    strb.arFromIr  = tt[2];
    strb.arFromMem = tt[3] & indFlag & ~dec[OP_HLT];
    strb.drLoad    = tt[4] & (dec[OP_AND] | dec[OP_ADD] | dec[OP_LDA] | dec[OP_ISZ]);
    strb.wrAc      = tt[4] & dec[OP_STA];
    strb.wrPc      = tt[4] & dec[OP_BSA];
    strb.arInc     = tt[4] & dec[OP_BSA];
    strb.pcFromAr  = (tt[4] & dec[OP_BUN]) | (tt[5] & dec[OP_BSA]);
    strb.acAnd     = tt[5] & dec[OP_AND];
    strb.acAdd     = tt[5] & dec[OP_ADD];
    strb.acFromDr  = tt[5] & dec[OP_LDA];
    strb.drInc     = tt[5] & dec[OP_ISZ];
    strb.wrDr      = tt[6] & dec[OP_ISZ];
    if (halted) strb = '0;
  end

  assign scClr = (tt[4] & (dec[OP_STA] | dec[OP_BUN]))
               | (tt[5] & (dec[OP_AND] | dec[OP_ADD] | dec[OP_LDA] | dec[OP_BSA]))
               | (tt[6] & dec[OP_ISZ]);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sc <= '0;
      halted <= 1'b0;
      indFlag <= 1'b0;
    end else if (!halted) begin
      if (haltNow) halted <= 1'b1;
      else if (scClr) sc <= '0;
      else sc <= sc + SC_W'(1);
      if (tt[2]) indFlag <= irHi[3];
    end
  end

  assign tState = sc;
endmodule

// File: rtl/acc_seq_dp.sv
module acc_seq_dp
  import acc_seq_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = DATA_W - 4,
  parameter logic [ADDR_W-1:0] START_PC = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  seq_strobe_t       strb,
  input  logic              ldEn,
  input  logic [ADDR_W-1:0] ldAddr,
  input  logic [DATA_W-1:0] ldData,
  input  logic [ADDR_W-1:0] peekAddr,
  output logic [DATA_W-1:0] peekData,
  output logic [ADDR_W-1:0] pc,
  output logic [ADDR_W-1:0] ar,
  output logic [DATA_W-1:0] ir,
  output logic [DATA_W-1:0] dr,
  output logic [DATA_W-1:0] ac,
  output logic              eFlag,
  output logic              drZero
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int PAD_W = DATA_W - ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] memRd;

  assign memRd = mem[ar];
  assign peekData = mem[peekAddr];
  assign drZero = (dr == '0);

  always_ff @(posedge clk) begin
    if (ldEn) mem[ldAddr] <= ldData;
    else if (strb.wrAc) mem[ar] <= ac;
    else if (strb.wrPc) mem[ar] <= {{PAD_W{1'b0}}, pc};
    else if (strb.wrDr) mem[ar] <= dr;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pc <= START_PC;
      ar <= '0;
      ir <= '0;
      dr <= '0;
      ac <= '0;
      eFlag <= 1'b0;
    end else begin
      if (strb.pcFromAr) pc <= ar;
      else if (strb.pcInc) pc <= pc + ADDR_W'(1);

      if (strb.arFromPc) ar <= pc;
      else if (strb.arFromIr) ar <= ir[ADDR_W-1:0];
      else if (strb.arFromMem) ar <= memRd[ADDR_W-1:0];
      else if (strb.arInc) ar <= ar + ADDR_W'(1);

      if (strb.irLoad) ir <= memRd;

      if (strb.drLoad) dr <= memRd;
      else if (strb.drInc) dr <= dr + DATA_W'(1);

      if (strb.acAnd) ac <= ac & dr;
      else if (strb.acAdd) {eFlag, ac} <= {1'b0, ac} + {1'b0, dr};
      else if (strb.acFromDr) ac <= dr;
    end
  end
endmodule

// File: rtl/acc_seq_top.sv
module acc_seq_top
  import acc_seq_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = DATA_W - 4,
  parameter logic [ADDR_W-1:0] START_PC = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ldEn,
  input  logic [ADDR_W-1:0] ldAddr,
  input  logic [DATA_W-1:0] ldData,
  input  logic [ADDR_W-1:0] peekAddr,
  output logic [DATA_W-1:0] peekData,
  output logic [ADDR_W-1:0] pc,
  output logic [ADDR_W-1:0] ar,
  output logic [DATA_W-1:0] ir,
  output logic [DATA_W-1:0] dr,
  output logic [DATA_W-1:0] ac,
  output logic              eFlag,
  output logic              indFlag,
  output logic [2:0]        tState,
  output logic              halted
);
  seq_strobe_t strb;
  logic drZero;

  acc_seq_ctrl ctrl_i (
    .clk(clk), .rstN(rstN),
    .irHi(ir[DATA_W-1:DATA_W-4]), .drZero(drZero),
    .strb(strb), .tState(tState), .indFlag(indFlag), .halted(halted)
  );

  acc_seq_dp #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .START_PC(START_PC)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb),
    .ldEn(ldEn), .ldAddr(ldAddr), .ldData(ldData),
    .peekAddr(peekAddr), .peekData(peekData),
    .pc(pc), .ar(ar), .ir(ir), .dr(dr), .ac(ac),
    .eFlag(eFlag), .drZero(drZero)
  );
endmodule

// File: rtl/acc_seq_checks.sv
module acc_seq_checks #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = DATA_W - 4
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] pc,
  input logic [ADDR_W-1:0] ar,
  input logic [DATA_W-1:0] ir,
  input logic [DATA_W-1:0] dr,
  input logic [DATA_W-1:0] ac,
  input logic              eFlag,
  input logic              indFlag,
  input logic [2:0]        tState,
  input logic              halted
);
  logic [2:0] op;
  assign op = ir[DATA_W-2:DATA_W-4];

  a_r1_t0_ar: assert property (@(posedge clk) disable iff (!rstN)
    (tState == 3'd0) |=> (ar == $past(pc)));

  a_r2_t1_pc: assert property (@(posedge clk) disable iff (!rstN)
    (tState == 3'd1) |=> (pc == $past(pc) + ADDR_W'(1)) && (tState == 3'd2));

  a_r3_t2_decode: assert property (@(posedge clk) disable iff (!rstN)
    (tState == 3'd2) |=> (ar == $past(ir[ADDR_W-1:0])) && (indFlag == $past(ir[DATA_W-1])));

  a_r4_direct_t3: assert property (@(posedge clk) disable iff (!rstN)
    (tState == 3'd3 && !indFlag && op != 3'd7) |=> $stable(ar) && $stable(ac) && $stable(pc));

  a_r5_add: assert property (@(posedge clk) disable iff (!rstN)
    (tState == 3'd5 && op == 3'd1) |=>
      ({eFlag, ac} == {1'b0, $past(ac)} + {1'b0, $past(dr)}) && (tState == 3'd0));

  a_r6_bun: assert property (@(posedge clk) disable iff (!rstN)
    (tState == 3'd4 && op == 3'd4) |=> (pc == $past(ar)) && (tState == 3'd0));

  a_r11_halt_hold: assert property (@(posedge clk) disable iff (!rstN)
    halted |=> halted && $stable(pc) && $stable(ac) && $stable(eFlag) && (tState == 3'd3));

  a_r11_state_range: assert property (@(posedge clk) disable iff (!rstN)
    tState <= 3'd6);
endmodule

bind acc_seq_top acc_seq_checks #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rstN(rstN), .pc(pc), .ar(ar), .ir(ir), .dr(dr), .ac(ac),
  .eFlag(eFlag), .indFlag(indFlag), .tState(tState), .halted(halted)
);

// File: tb/acc_seq_top_tb_top.sv
`timescale 1ns/1ps
module acc_seq_top_tb_top;
  localparam logic [11:0] BOOT = 12'h29E;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ldEn = 1'b0;
  logic [11:0] ldAddr = '0;
  logic [15:0] ldData = '0;
  logic [11:0] peekAddr = '0;
  logic [15:0] peekData;
  logic [11:0] pc, ar;
  logic [15:0] ir, dr, ac;
  logic eFlag, indFlag, halted;
  logic [2:0] tState;

  int nChecks = 0;
  int nFail = 0;
  int runCycles = 0;

  always #5 clk = ~clk;

  acc_seq_top #(.START_PC(BOOT)) dut_i (
    .clk(clk), .rstN(rstN), .ldEn(ldEn), .ldAddr(ldAddr), .ldData(ldData),
    .peekAddr(peekAddr), .peekData(peekData), .pc(pc), .ar(ar), .ir(ir),
    .dr(dr), .ac(ac), .eFlag(eFlag), .indFlag(indFlag), .tState(tState),
    .halted(halted)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic poke(input logic [11:0] a, input logic [15:0] d);
    @(negedge clk);
    ldEn = 1'b1; ldAddr = a; ldData = d;
    @(negedge clk);
    ldEn = 1'b0;
  endtask

  function automatic logic [15:0] peek(input logic [11:0] a);
    peekAddr = a;
    return dut_i.dp_i.mem[a];
  endfunction

  task automatic peekChk(input logic [11:0] a, input logic [15:0] exp, input string tag);
    peekAddr = a;
    #1;
    check(peekData == exp, tag, peekData, exp);
  endtask

  task automatic holdReset;
    @(negedge clk);
    rstN = 1'b0;
  endtask

  task automatic run;
    @(negedge clk);
    rstN = 1'b1;
    runCycles = 0;
    while (!halted && runCycles < 300) begin
      @(negedge clk);
      runCycles++;
    end
    if (!halted) check(1'b0, "watchdog run", runCycles, 0);
  endtask

  initial begin
    #(200000 * 10);
    check(1'b0, "watchdog global", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    logic [16:0] sum;
    logic [15:0] a, b, v, nv;

    // R13 reset state
    repeat (2) @(negedge clk);
    check(pc == BOOT, "R13 pc", pc, BOOT);
    check(ac == 16'h0 && eFlag == 1'b0, "R13 ac/e", {ac, 15'b0, eFlag}, 0);
    check(tState == 3'd0 && halted == 1'b0, "R13 state", {tState, halted}, 0);

    // R12 load and peek
    poke(12'h7AB, 16'h5A3C);
    peekChk(12'h7AB, 16'h5A3C, "R12 load/peek");

    // Branch, indirect branch and add: R1 R2 R3 R4 R5 R6
    holdReset();
    poke(12'h29E, 16'h22F0); poke(12'h2F0, 16'hA35F);
    poke(12'h29F, 16'h42A2);
    poke(12'h2A2, 16'hC000); poke(12'h000, 16'h0446);
    poke(12'h446, 16'h1F03); poke(12'hF03, 16'h2A45);
    poke(12'h447, 16'h7000);
    run();
    check(ac == 16'hCDA4, "R5 worked ac", ac, 16'hCDA4);
    check(eFlag == 1'b0, "R5 worked e", eFlag, 0);
    check(pc == 12'h448, "R6 worked pc", pc, 12'h448);
    check(runCycles == 26, "R4 worked cycles", runCycles, 26);
    check(ir == 16'h7000 && ar == 12'h000, "R3 halt decode", {ir, 4'b0, ar}, {16'h7000, 16'h0});

    // ADD/STA sweep: R5 R8
    for (int i = 0; i < 9; i++) begin
      a = (i == 8) ? 16'hFFFF : 16'(i * 16'h3A71);
      b = (i == 8) ? 16'h0001 : 16'(16'hFFFF - i * 16'h0123);
      sum = {1'b0, a} + {1'b0, b};
      holdReset();
      poke(12'h29E, 16'h2300); poke(12'h29F, 16'h1301);
      poke(12'h2A0, 16'h3302); poke(12'h2A1, 16'h7000);
      poke(12'h300, a); poke(12'h301, b); poke(12'h302, 16'h0000);
      run();
      check(ac == sum[15:0], "R5 add sum", ac, sum[15:0]);
      check(eFlag == sum[16], "R5 add carry", eFlag, sum[16]);
      peekChk(12'h302, sum[15:0], "R8 sta store");
      if (i == 0) check(runCycles == 21, "R8 cycles", runCycles, 21);
    end

    // AND and LDA keep E: R7
    for (int i = 0; i < 4; i++) begin
      a = 16'(16'hF0F0 ^ (i * 16'h1357));
      b = 16'(16'h3CC3 + i * 16'h0F11);
      holdReset();
      poke(12'h29E, 16'h2300); poke(12'h29F, 16'h1301);
      poke(12'h2A0, 16'h2302); poke(12'h2A1, 16'h0303); poke(12'h2A2, 16'h7000);
      poke(12'h300, 16'hFFFF); poke(12'h301, 16'h0001);
      poke(12'h302, a); poke(12'h303, b);
      run();
      check(ac == (a & b), "R7 and result", ac, a & b);
      check(eFlag == 1'b1, "R7 e kept", eFlag, 1);
    end

    // Indirect versus direct load: R4
    holdReset();
    poke(12'h29E, 16'hA300); poke(12'h29F, 16'h7000);
    poke(12'h300, 16'h0350); poke(12'h350, 16'hBEEF);
    run();
    check(ac == 16'hBEEF, "R4 indirect lda", ac, 16'hBEEF);
    holdReset();
    poke(12'h29E, 16'h2300);
    run();
    check(ac == 16'h0350, "R4 direct lda", ac, 16'h0350);

    // BSA then halt hold: R9 R11
    holdReset();
    poke(12'h29E, 16'h5310); poke(12'h311, 16'h2310); poke(12'h312, 16'h7000);
    poke(12'h310, 16'h0000);
    run();
    peekChk(12'h310, 16'h029F, "R9 bsa saved pc");
    check(ac == 16'h029F, "R9 bsa return read", ac, 16'h029F);
    check(pc == 12'h313, "R9 bsa pc", pc, 12'h313);
    repeat (6) @(negedge clk);
    check(pc == 12'h313 && ac == 16'h029F && tState == 3'd3 && halted,
          "R11 halt hold", {pc, 1'b0, tState, ac}, {12'h313, 1'b0, 3'd3, 16'h029F});

    // ISZ sweep: R10
    for (int i = 0; i < 4; i++) begin
      case (i)
        0: v = 16'hFFFF;
        1: v = 16'h0005;
        2: v = 16'h0000;
        default: v = 16'h7FFF;
      endcase
      nv = v + 16'h1;
      holdReset();
      poke(12'h29E, 16'h6320); poke(12'h29F, 16'h7000); poke(12'h2A0, 16'h7000);
      poke(12'h320, v);
      run();
      peekChk(12'h320, nv, "R10 isz write");
      check(pc == ((nv == 16'h0) ? 12'h2A1 : 12'h2A0), "R10 isz skip", pc,
            (nv == 16'h0) ? 12'h2A1 : 12'h2A0);
      if (i == 0) check(runCycles == 11, "R10 cycles", runCycles, 11);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule